// File: doc/BRIEF.md
# Reservation-Wait Stall Controller

This block recognises the two wait-on-reservation instructions of a RISC-V hart and holds the hart while it waits. One form, called short-wait here, bounds the wait with a brief timer. The other form, called open-wait here, has no architectural bound. While the block waits, it keeps the hart stalled for as long as three conditions all hold: the load-reserved reservation is still valid, no locally enabled interrupt is pending, and the block's own timer has not run out. When the wait ends, the block issues one retire pulse or one illegal-instruction pulse.

An open-wait that times out below machine mode with the timeout-wait control bit set must trap rather than retire. An open-wait issued in machine mode arms no timer at all, so only the loss of the reservation or an interrupt can end it. The timer lengths are parameters. Decoding, stall and the exit pulses all come from combinational logic, so a wait whose exit condition already holds when it is issued finishes in its issue cycle and never raises stall.

Top module: `resv_wait_ctrl`

## Requirements
- R1: With `insn_valid` high, the word 0x01D00073 is accepted as a short-wait. Its fields are bits[31:20]=0x01D, bits[19:7] all zero and opcode bits[6:0]=1110011.
- R2: With `insn_valid` high, the word 0x00D00073 (bits[31:20]=0x00D, other fields as in R1) is accepted as an open-wait.
- R3: A word that differs from both encodings in any field, or any word presented while `insn_valid` is low, produces no stall, no retire and no illegal pulse.
- R4: If the reservation is invalid or `irq_pend & irq_en` is nonzero in the issue cycle, `retire` pulses in that same cycle and `stall` stays low.
- R5: Once accepted, `stall` stays high in every cycle in which the reservation is valid, `irq_pend & irq_en` is zero and the timer has not expired.
- R6: Loss of the reservation during a wait ends it in that cycle with `retire`, for either form, at any privilege level and with either setting of `trap_wait`.
- R7: A pending interrupt whose bit is also set in `irq_en` ends the wait in that cycle with `retire`. A pending bit that is not enabled has no effect.
- R8: A short-wait that keeps its exit conditions false stalls for exactly SHORT_TIMEOUT cycles and then pulses `retire`, whatever the privilege level and `trap_wait`.
- R9: An open-wait issued at privilege 2'b11 (machine) arms no timer and stays stalled for as long as the reservation is held and no enabled interrupt is pending.
- R10: An open-wait issued at privilege 2'b00 or 2'b01 with `trap_wait` low stalls for exactly LONG_TIMEOUT cycles and then pulses `retire`.
- R11: An open-wait below machine mode with `trap_wait` high stalls for exactly LONG_TIMEOUT cycles and then pulses `illegal` instead of `retire`.
- R12: The timer is cleared whenever a wait ends, so every new wait gets its full timeout regardless of how the previous one ended.
- R13: `retire` and `illegal` are never high together, and `stall` is low in any cycle in which either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word to decode |
| resv_valid | input | 1 | Load-reserved reservation is held |
| irq_pend | input | IRQ_W | Pending interrupt vector |
| irq_en | input | IRQ_W | Interrupt enable vector |
| priv_lvl | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| trap_wait | input | 1 | Timeout-wait trap control bit |
| stall | output | 1 | Hold the hart this cycle |
| retire | output | 1 | Wait instruction retires this cycle |
| illegal | output | 1 | Illegal-instruction exception this cycle |

## Verification
The hardest case to reach is the trap: an open-wait issued below machine mode must keep its reservation for the full LONG_TIMEOUT cycles, with no enabled interrupt, while `trap_wait` is high. The bench drives that case with a task that holds the reservation steady and counts stall cycles until a pulse appears. The same task can drop the reservation, or raise an enabled or a masked interrupt, at a chosen cycle, which also covers the exits in the middle of a wait and the timer clear between back-to-back waits.

// File: rtl/resv_wait_pkg.sv
package resv_wait_pkg;

  localparam logic [6:0]  OPC_SYSTEM  = 7'b1110011;
  localparam logic [11:0] F12_SHORT   = 12'h01D;
  localparam logic [11:0] F12_OPEN    = 12'h00D;
  localparam logic [1:0]  PRIV_MACH   = 2'b11;

  typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } wstate_e;
  typedef enum logic { VAR_SHORT = 1'b0, VAR_OPEN = 1'b1 } wvar_e;

endpackage

// File: rtl/resv_wait_decode.sv
module resv_wait_decode
  import resv_wait_pkg::*;
(
  input  logic [31:0] word_i,
  output logic        hit_o,
  output logic        short_o
);

  logic zero_fields;
  logic is_short;
  logic is_open;

  always_comb begin
    zero_fields = (word_i[19:7] == 13'd0) && (word_i[6:0] == OPC_SYSTEM);
    is_short    = zero_fields && (word_i[31:20] == F12_SHORT);
    is_open     = zero_fields && (word_i[31:20] == F12_OPEN);
    hit_o       = is_short || is_open;
    short_o     = is_short;
  end

endmodule

// File: rtl/resv_wait_timer.sv
module resv_wait_timer #(
  parameter int SHORT_TIMEOUT = 16,
  parameter int LONG_TIMEOUT  = 256,
  parameter int CNT_W         = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic start_short_i,
  input  logic start_armed_i,
  input  logic clr_i,
  output logic expired_o
);

  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT_TIMEOUT);
  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_TIMEOUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             short_q, short_d;
  logic             armed_q, armed_d;
  logic             cnt_en;
  logic [CNT_W-1:0] limit;

  always_comb begin
    cnt_en  = start_i || clr_i || (armed_q && (cnt_q != '1));
    cnt_d   = cnt_q;
    short_d = short_q;
    armed_d = armed_q;
    if (start_i) begin
      cnt_d   = CNT_W'(1);
      short_d = start_short_i;
      armed_d = start_armed_i;
    end else if (clr_i) begin
      cnt_d   = '0;
      short_d = 1'b0;
      armed_d = 1'b0;
    end else if (armed_q && (cnt_q != '1)) begin
      cnt_d   = cnt_q + CNT_W'(1);
    end
    limit     = short_q ? SHORT_L : LONG_L;
    expired_o = armed_q && (cnt_q >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      short_q <= short_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/resv_wait_ctrl.sv
module resv_wait_ctrl
  import resv_wait_pkg::*;
#(
  parameter int IRQ_W         = 16,
  parameter int SHORT_TIMEOUT = 16,
  parameter int LONG_TIMEOUT  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  input  logic [31:0]      insn_word,
  input  logic             resv_valid,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic [1:0]       priv_lvl,
  input  logic             trap_wait,
  output logic             stall,
  output logic             retire,
  output logic             illegal
);

  localparam int CNT_W = $clog2(LONG_TIMEOUT + 1);

  logic    dec_hit, dec_short;
  logic    tmr_start, tmr_clr, tmr_expired;
  logic    irq_live, below_mach, wait_done, timed_out;
  wstate_e st_q, st_d;
  wvar_e   var_q, var_d;
  logic    st_en;

  resv_wait_decode u_dec (
    .word_i  (insn_word),
    .hit_o   (dec_hit),
    .short_o (dec_short)
  );

  resv_wait_timer #(
    .SHORT_TIMEOUT (SHORT_TIMEOUT),
    .LONG_TIMEOUT  (LONG_TIMEOUT),
    .CNT_W         (CNT_W)
  ) u_tmr (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (tmr_start),
    .start_short_i (dec_short),
    .start_armed_i (dec_short || below_mach),
    .clr_i         (tmr_clr),
    .expired_o     (tmr_expired)
  );

  always_comb begin
    irq_live   = |(irq_pend & irq_en);
    below_mach = (priv_lvl != PRIV_MACH);
    wait_done  = !resv_valid || irq_live || tmr_expired;
    timed_out  = resv_valid && !irq_live;
    st_d       = st_q;
    var_d      = var_q;
    stall      = 1'b0;
    retire     = 1'b0;
    illegal    = 1'b0;
    tmr_start  = 1'b0;
    tmr_clr    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (insn_valid && dec_hit) begin
          if (!resv_valid || irq_live) begin
            retire = 1'b1;
          end else begin
            stall     = 1'b1;
            tmr_start = 1'b1;
            st_d      = ST_WAIT;
            var_d     = dec_short ? VAR_SHORT : VAR_OPEN;
          end
        end
      end
      ST_WAIT: begin
        if (wait_done) begin
          tmr_clr = 1'b1;
          st_d    = ST_IDLE;
          if ((var_q == VAR_OPEN) && timed_out && below_mach && trap_wait)
            illegal = 1'b1;
          else
            retire  = 1'b1;
        end else begin
          stall = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    st_en = (st_d != st_q) || (var_d != var_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      var_q <= VAR_SHORT;
    end else if (st_en) begin
      st_q  <= st_d;
      var_q <= var_d;
    end
  end

endmodule

// File: rtl/resv_wait_checker.sv
module resv_wait_checker #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resv_valid,
  input logic [IRQ_W-1:0] irq_pend,
  input logic [IRQ_W-1:0] irq_en,
  input logic [1:0]       priv_lvl,
  input logic             trap_wait,
  input logic             stall,
  input logic             retire,
  input logic             illegal
);

  p_excl_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && illegal));

  p_no_stall_on_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (retire || illegal) |-> !stall);

  p_stall_needs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (resv_valid && ((irq_pend & irq_en) == '0)));

  p_trap_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (resv_valid && trap_wait && (priv_lvl != 2'b11)
                 && ((irq_pend & irq_en) == '0)));

  p_trap_after_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(stall));

endmodule

bind resv_wait_ctrl resv_wait_checker #(.IRQ_W(IRQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .resv_valid (resv_valid),
  .irq_pend   (irq_pend),
  .irq_en     (irq_en),
  .priv_lvl   (priv_lvl),
  .trap_wait  (trap_wait),
  .stall      (stall),
  .retire     (retire),
  .illegal    (illegal)
);

// File: tb/resv_wait_ctrl_test.sv
module resv_wait_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W      = 16;
  localparam int SHORT_T    = 16;
  localparam int LONG_T     = 256;
  localparam logic [31:0] W_SHORT = 32'h01D00073;
  localparam logic [31:0] W_OPEN  = 32'h00D00073;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             insn_valid;
  logic [31:0]      insn_word;
  logic             resv_valid;
  logic [IRQ_W-1:0] irq_pend;
  logic [IRQ_W-1:0] irq_en;
  logic [1:0]       priv_lvl;
  logic             trap_wait;
  logic             stall, retire, illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_wait_ctrl #(.IRQ_W(IRQ_W), .SHORT_TIMEOUT(SHORT_T), .LONG_TIMEOUT(LONG_T)) uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .resv_valid(resv_valid), .irq_pend(irq_pend), .irq_en(irq_en),
    .priv_lvl(priv_lvl), .trap_wait(trap_wait),
    .stall(stall), .retire(retire), .illegal(illegal)
  );

  typedef struct packed {
    logic        vld;
    logic [31:0] word;
    logic        resv;
    logic [15:0] pend;
    logic [15:0] en;
    logic [1:0]  priv;
    logic        tw;
    logic [2:0]  exp;   // stall, retire, illegal
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b1, W_SHORT,      1'b0, 16'h0000, 16'h0000, 2'b00, 1'b1, 3'b010}, // R1 R4
    '{1'b1, W_OPEN,       1'b0, 16'h0000, 16'h0000, 2'b00, 1'b1, 3'b010}, // R2 R4
    '{1'b1, W_SHORT,      1'b1, 16'h0080, 16'h0080, 2'b11, 1'b0, 3'b010}, // R4 R7
    '{1'b1, W_OPEN,       1'b1, 16'h0008, 16'h0080, 2'b00, 1'b0, 3'b100}, // R7 masked
    '{1'b1, 32'h01D00077, 1'b0, 16'h0000, 16'h0000, 2'b00, 1'b0, 3'b000}, // R3 opcode
    '{1'b1, 32'h01D000F3, 1'b0, 16'h0000, 16'h0000, 2'b00, 1'b0, 3'b000}, // R3 rd
    '{1'b1, 32'h00C00073, 1'b0, 16'h0000, 16'h0000, 2'b00, 1'b0, 3'b000}, // R3 funct12
    '{1'b0, W_SHORT,      1'b0, 16'h0000, 16'h0000, 2'b00, 1'b0, 3'b000}, // R3 not valid
    '{1'b1, W_SHORT,      1'b1, 16'h0000, 16'hFFFF, 2'b11, 1'b0, 3'b100}, // R1 R5
    '{1'b1, W_OPEN,       1'b1, 16'h0000, 16'h0000, 2'b01, 1'b1, 3'b100}  // R2 R5
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    insn_valid = 1'b0;
    insn_word  = 32'h0;
    resv_valid = 1'b0;
    irq_pend   = '0;
    irq_en     = '0;
    priv_lvl   = 2'b11;
    trap_wait  = 1'b0;
  endtask

  // Issue at a negedge; runs until a pulse or limit cycles.
  task automatic run_wait(input logic [31:0] w, input logic [1:0] pv, input logic tw,
                          input int drop_at, input int irq_at, input logic [15:0] irq_bit,
                          input int limit, output int nstall, output bit got_ret,
                          output bit got_ill);
    nstall  = 0;
    got_ret = 1'b0;
    got_ill = 1'b0;
    priv_lvl  = pv;
    trap_wait = tw;
    irq_en    = 16'h0F0F;
    for (int c = 0; c < limit; c++) begin
      insn_valid = (c == 0);
      insn_word  = w;
      resv_valid = (c != drop_at);
      irq_pend   = (c == irq_at) ? irq_bit : 16'h0;
      #(CLK_PERIOD/4);
      if (retire)  got_ret = 1'b1;
      if (illegal) got_ill = 1'b1;
      if (retire || illegal) break;
      if (stall) nstall++;
      @(negedge clk);
    end
    if (!(got_ret || got_ill)) begin
      resv_valid = 1'b0;
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);
  endtask

  initial begin
    int ns;
    bit r, il;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 reset stall",   int'(stall),   0);
    check("R13 reset retire",  int'(retire),  0);
    check("R13 reset illegal", int'(illegal), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      insn_valid = TBL[i].vld;
      insn_word  = TBL[i].word;
      resv_valid = TBL[i].resv;
      irq_pend   = TBL[i].pend;
      irq_en     = TBL[i].en;
      priv_lvl   = TBL[i].priv;
      trap_wait  = TBL[i].tw;
      #(CLK_PERIOD/4);
      check($sformatf("R1-vec%0d stall (R3 R4 R5)", i),  int'(stall),   int'(TBL[i].exp[2]));
      check($sformatf("R2-vec%0d retire (R4 R7)", i),    int'(retire),  int'(TBL[i].exp[1]));
      check($sformatf("R13-vec%0d illegal", i),          int'(illegal), int'(TBL[i].exp[0]));
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
    end

    // R8: short-wait runs to its timeout, even below M with trap_wait set
    run_wait(W_SHORT, 2'b00, 1'b1, -1, -1, 16'h0, LONG_T + 40, ns, r, il);
    check("R8 short stall cycles", ns, SHORT_T);
    check("R8 short retire", int'(r), 1);
    check("R8 short no illegal", int'(il), 0);

    // R10: open-wait, supervisor, trap_wait low
    run_wait(W_OPEN, 2'b01, 1'b0, -1, -1, 16'h0, LONG_T + 40, ns, r, il);
    check("R10 open stall cycles", ns, LONG_T);
    check("R10 open retire", int'(r), 1);
    check("R10 open no illegal", int'(il), 0);

    // R11: open-wait, user, trap_wait high
    run_wait(W_OPEN, 2'b00, 1'b1, -1, -1, 16'h0, LONG_T + 40, ns, r, il);
    check("R11 open stall cycles", ns, LONG_T);
    check("R11 illegal", int'(il), 1);
    check("R11 no retire", int'(r), 0);

    // R9: open-wait in machine mode never times out; then R6 drop ends it
    run_wait(W_OPEN, 2'b11, 1'b1, LONG_T + 30, -1, 16'h0, LONG_T + 40, ns, r, il);
    check("R9 machine stall cycles", ns, LONG_T + 30);
    check("R6 machine drop retire", int'(r), 1);
    check("R9 machine no illegal", int'(il), 0);

    // R6: reservation loss mid open-wait with trap_wait set
    run_wait(W_OPEN, 2'b00, 1'b1, 10, -1, 16'h0, LONG_T + 40, ns, r, il);
    check("R6 drop stall cycles", ns, 10);
    check("R6 drop retire", int'(r), 1);
    check("R6 drop no illegal", int'(il), 0);

    // R7: masked interrupt has no effect (runs to timeout)
    run_wait(W_SHORT, 2'b00, 1'b0, -1, 4, 16'h1000, LONG_T + 40, ns, r, il);
    check("R7 masked irq stall cycles", ns, SHORT_T);

    // R7: enabled interrupt ends the wait
    run_wait(W_SHORT, 2'b00, 1'b0, -1, 5, 16'h0100, LONG_T + 40, ns, r, il);
    check("R7 irq stall cycles", ns, 5);
    check("R7 irq retire", int'(r), 1);

    // R12: next wait gets a full timeout after an early exit
    run_wait(W_SHORT, 2'b00, 1'b0, -1, -1, 16'h0, LONG_T + 40, ns, r, il);
    check("R12 fresh timer stall cycles", ns, SHORT_T);
    check("R12 fresh timer retire", int'(r), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule